// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator

This block sits beside a real-time clock's time counter and decides, once per one-second update, whether the running time has reached the programmed alarm. On each update strobe it captures the freshly updated seconds, minutes and hours fields, together with the three alarm bytes and the mode settings. In the following cycle it compares the captured values and raises a single-cycle match pulse. Flag storage and interrupt enabling are left to the status logic that consumes the pulse.

An alarm byte whose two most significant bits are both 1 is a wildcard and matches any value of its field. With only the seconds alarm wild, the alarm fires once per second during the programmed minute. With seconds and minutes wild, it fires every second of the programmed hour. With all three wild, it fires on every update. Fields are decoded as BCD or binary, and the hour is read in 12-hour or 24-hour form, under the same settings the time counter uses. In 12-hour form bit 7 of the hour marks PM, and the hour value 12 stands for the first hour of the half-day. While the time counter is held for setting, an update strobe is ignored.

The control is a two-state machine. `ST_IDLE` waits for a strobe. The transition *capture* (strobe with hold low) latches all inputs and moves to `ST_EVAL`. The transition *hold-skip* (strobe with hold high) stays in `ST_IDLE`. `ST_EVAL` always returns to `ST_IDLE` on the next clock through the transition *evaluate*, which registers the match pulse. A strobe that arrives while the machine is in `ST_EVAL` is dropped.

Top module: `tod_alarm_cmp`

## Requirements
- R1: After reset `alarm_hit` is 0 and stays 0 until a strobe has been evaluated.
- R2: An alarm byte with bits 7:6 = 2'b11 matches any value of its field, while the other fields must still match.
- R3: With all three alarm bytes wild, every accepted strobe produces a match pulse, whatever the time.
- R4: With `bin_mode`=1 the fields are plain binary; with `bin_mode`=0 each byte is BCD (tens in bits 7:4, units in bits 3:0). Both the time and the alarm are decoded in the same mode before comparison.
- R5: With `h24_mode`=0 the hour bytes carry the hour 1..12 in bits 6:0 and PM in bit 7. The alarm hour and the current hour are both normalised to 0..23 before comparison, so 12 AM and 12 PM differ.
- R6: A strobe sampled at clock edge k gives `alarm_hit` high for exactly one cycle, from edge k+1 to edge k+2. The pulse never lasts two cycles.
- R7: A strobe sampled with `set_hold`=1 produces no match pulse, even when the time equals the alarm.
- R8: The comparison uses the time and alarm values present at the strobe edge. Alarm values written before the strobe take effect at that strobe, and changes after it do not alter its result.
- R9: A strobe sampled in the cycle directly after an accepted strobe (state `ST_EVAL`) is ignored and produces no pulse.
- R10: When any non-wild field differs from the time, no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd_tick | input | 1 | One-second update strobe, time fields already updated |
| set_hold | input | 1 | Time counter held for setting; strobes are ignored |
| bin_mode | input | 1 | 1 = binary fields, 0 = BCD fields |
| h24_mode | input | 1 | 1 = 24-hour, 0 = 12-hour with PM in bit 7 |
| now_sec | input | 8 | Current seconds |
| now_min | input | 8 | Current minutes |
| now_hr | input | 8 | Current hours |
| alm_sec | input | 8 | Seconds alarm byte |
| alm_min | input | 8 | Minutes alarm byte |
| alm_hr | input | 8 | Hours alarm byte |
| alarm_hit | output | 1 | One-cycle alarm match pulse |

## Verification
The only result is `alarm_hit`. It is due two edges after the strobe: the strobe is captured at edge k and the pulse is registered at edge k+1. The bench records the strobe through a two-stage shift register clocked at each rising edge. At the falling edge where the second stage is set, it pops the one expected value that the driver pushed with that strobe. At every other falling edge it requires `alarm_hit` to be 0, which catches pulses that are late, stretched or unexpected. Dropped strobes (held or back-to-back) still push an expected 0, so their absence of a pulse is checked in the cycle where a pulse would have appeared.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EVAL = 1'b1
    } cmp_state_t;

    // Decode one field byte into its numeric value.
    function automatic logic [7:0] field_value(input logic [7:0] raw, input logic bin);
        logic [7:0] tens;
        if (bin) begin
            field_value = raw;
        end else begin
            tens = {4'd0, raw[7:4]};
            field_value = (tens << 3) + (tens << 1) + {4'd0, raw[3:0]};
        end
    endfunction

    // Normalise an hour byte to 0..23 under the active hour format.
    function automatic logic [7:0] hour_value(input logic [7:0] raw, input logic bin,
                                              input logic h24);
        logic [7:0] h;
        if (h24) begin
            hour_value = field_value(raw, bin);
        end else begin
            h = field_value({1'b0, raw[6:0]}, bin);
            if (h == 8'd12) h = 8'd0;
            if (raw[7]) h = h + 8'd12;
            hour_value = h;
        end
    endfunction

endpackage

// File: rtl/tod_alarm_field.sv
module tod_alarm_field
    import tod_alarm_pkg::*;
#(
    parameter int DW      = 8,
    parameter bit IS_HOUR = 1'b0
) (
    input  logic [DW-1:0] now_val,
    input  logic [DW-1:0] alm_val,
    input  logic          bin_mode,
    input  logic          h24_mode,
    output logic          field_hit
);
    localparam int TOP = DW - 1;

    logic          wild;
    logic [DW-1:0] now_norm;
    logic [DW-1:0] alm_norm;

    assign wild = alm_val[TOP] & alm_val[TOP-1];

    generate
        if (IS_HOUR) begin : g_hour
            assign now_norm = hour_value(now_val, bin_mode, h24_mode);
            assign alm_norm = hour_value(alm_val, bin_mode, h24_mode);
        end else begin : g_plain
            assign now_norm = field_value(now_val, bin_mode);
            assign alm_norm = field_value(alm_val, bin_mode);
        end
    endgenerate

    assign field_hit = wild | (now_norm == alm_norm);

endmodule

// File: rtl/tod_alarm_cmp.sv
module tod_alarm_cmp
    import tod_alarm_pkg::*;
#(
    parameter int DW     = 8,
    parameter int FIELDS = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_tick,
    input  logic          set_hold,
    input  logic          bin_mode,
    input  logic          h24_mode,
    input  logic [DW-1:0] now_sec,
    input  logic [DW-1:0] now_min,
    input  logic [DW-1:0] now_hr,
    input  logic [DW-1:0] alm_sec,
    input  logic [DW-1:0] alm_min,
    input  logic [DW-1:0] alm_hr,
    output logic          alarm_hit
);
    localparam int HOUR_IDX = FIELDS - 1;

    cmp_state_t state_q, state_d;

    logic [FIELDS-1:0][DW-1:0] now_in, alm_in;
    logic [FIELDS-1:0][DW-1:0] now_cap, alm_cap;
    logic                      bin_cap, h24_cap;
    logic [FIELDS-1:0]         field_hit;
    logic [FIELDS-1:0]         alm_wild;
    logic                      capture;
    logic                      hit_q;

    assign now_in  = {now_hr, now_min, now_sec};
    assign alm_in  = {alm_hr, alm_min, alm_sec};
    assign capture = (state_q == ST_IDLE) && upd_tick && !set_hold;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (capture) state_d = ST_EVAL;
            ST_EVAL: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture of time, alarm and mode at an accepted strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            now_cap <= '0;
            alm_cap <= '0;
            bin_cap <= 1'b0;
            h24_cap <= 1'b0;
        end else if (capture) begin
            now_cap <= now_in;
            alm_cap <= alm_in;
            bin_cap <= bin_mode;
            h24_cap <= h24_mode;
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < FIELDS; gi++) begin : g_field
            tod_alarm_field #(
                .DW      (DW),
                .IS_HOUR (gi == HOUR_IDX)
            ) u_field (
                .now_val   (now_cap[gi]),
                .alm_val   (alm_cap[gi]),
                .bin_mode  (bin_cap),
                .h24_mode  (h24_cap),
                .field_hit (field_hit[gi])
            );
            assign alm_wild[gi] = alm_cap[gi][DW-1] & alm_cap[gi][DW-2];
        end
    endgenerate

    // Output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hit_q <= 1'b0;
        else        hit_q <= (state_q == ST_EVAL) && (&field_hit);
    end

    assign alarm_hit = hit_q;

    // R6: pulse is a single cycle
    p_hit_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |=> !alarm_hit);

    // R6: a pulse only follows an evaluation cycle
    p_hit_after_eval_r6: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |-> $past(state_q == ST_EVAL));

    // R7: a held strobe does not start an evaluation and yields no pulse
    p_hold_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && upd_tick && set_hold) |=> (state_q == ST_IDLE) ##1 !alarm_hit);

    // R3: all alarm fields wild always produce a pulse
    p_all_wild_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVAL && (&alm_wild)) |=> alarm_hit);

    // R9: evaluation lasts one cycle regardless of strobes
    p_eval_drops_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVAL) |=> (state_q == ST_IDLE));

endmodule

// File: tb/tod_alarm_cmp_test.sv
module tod_alarm_cmp_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       upd_tick = 1'b0;
    logic       set_hold = 1'b0;
    logic       bin_mode = 1'b0;
    logic       h24_mode = 1'b1;
    logic [7:0] now_sec = '0, now_min = '0, now_hr = '0;
    logic [7:0] alm_sec = '0, alm_min = '0, alm_hr = '0;
    logic       alarm_hit;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    typedef struct {
        bit    exp;
        string tag;
    } exp_item_t;

    exp_item_t sb[$];
    logic [1:0] tick_sh = 2'b00;

    always #10 clk = ~clk;

    tod_alarm_cmp uut (
        .clk(clk), .rst_n(rst_n), .upd_tick(upd_tick), .set_hold(set_hold),
        .bin_mode(bin_mode), .h24_mode(h24_mode),
        .now_sec(now_sec), .now_min(now_min), .now_hr(now_hr),
        .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr),
        .alarm_hit(alarm_hit)
    );

    always @(posedge clk) tick_sh <= {tick_sh[0], upd_tick};

    // Monitor: compare at the falling edge after the pulse is due
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && tick_sh[1]) begin
                tests++;
                if (sb.size() == 0) begin
                    fails++;
                    $display("FAIL scoreboard empty: actual %0b expected none", alarm_hit);
                end else begin
                    exp_item_t it;
                    it = sb.pop_front();
                    if (alarm_hit !== it.exp) begin
                        fails++;
                        $display("FAIL %s: actual %0b expected %0b", it.tag, alarm_hit, it.exp);
                    end
                end
            end else if (rst_n && alarm_hit !== 1'b0) begin
                tests++;
                fails++;
                $display("FAIL R6 stray pulse: actual %0b expected 0", alarm_hit);
            end
        end
    end

    task automatic set_vals(input logic [7:0] s, m, h, as, am, ah);
        now_sec = s; now_min = m; now_hr = h;
        alm_sec = as; alm_min = am; alm_hr = ah;
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Driver: one strobe with its expected result
    task automatic strobe(input logic [7:0] s, m, h, as, am, ah,
                          input bit exp, input string tag);
        exp_item_t it;
        @(negedge clk);
        set_vals(s, m, h, as, am, ah);
        upd_tick = 1'b1;
        it.exp = exp; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        upd_tick = 1'b0;
        gap(3);
    endtask

    initial begin
        #200_000_000;
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        exp_item_t it;
        gap(3);
        tests++;
        if (alarm_hit !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: actual %0b expected 0", alarm_hit);
        end
        rst_n = 1'b1;
        gap(3);
        tests++;
        if (alarm_hit !== 1'b0) begin
            fails++;
            $display("FAIL R1 after release: actual %0b expected 0", alarm_hit);
        end

        // BCD, 24-hour
        bin_mode = 1'b0; h24_mode = 1'b1;
        strobe(8'h56, 8'h34, 8'h12, 8'h56, 8'h34, 8'h12, 1'b1, "R4 bcd exact match");
        strobe(8'h57, 8'h34, 8'h12, 8'h56, 8'h34, 8'h12, 1'b0, "R10 seconds differ");
        strobe(8'h56, 8'h35, 8'h12, 8'h56, 8'h34, 8'h12, 1'b0, "R10 minutes differ");
        strobe(8'h56, 8'h34, 8'h13, 8'h56, 8'h34, 8'h12, 1'b0, "R10 hours differ");
        strobe(8'h07, 8'h34, 8'h12, 8'hC0, 8'h34, 8'h12, 1'b1, "R2 wild seconds");
        strobe(8'h07, 8'h11, 8'h12, 8'hC0, 8'hFF, 8'h12, 1'b1, "R2 wild sec+min");
        strobe(8'h07, 8'h11, 8'h09, 8'hC0, 8'hFF, 8'h12, 1'b0, "R2 wild fields but hour differs");
        strobe(8'h00, 8'h00, 8'h00, 8'hC0, 8'hC0, 8'hC0, 1'b1, "R3 all wild 00:00:00");
        strobe(8'h59, 8'h59, 8'h23, 8'hC0, 8'hC0, 8'hC0, 1'b1, "R3 all wild 23:59:59");
        strobe(8'h31, 8'h02, 8'h17, 8'hC5, 8'hD1, 8'hFF, 1'b1, "R3 all wild other codes");

        // Binary mode
        bin_mode = 1'b1;
        strobe(8'h3B, 8'h00, 8'h17, 8'h3B, 8'h00, 8'h17, 1'b1, "R4 binary 59s match");
        strobe(8'h3B, 8'h00, 8'h17, 8'h59, 8'h00, 8'h17, 1'b0, "R4 binary 59 vs 0x59");

        // 12-hour BCD
        bin_mode = 1'b0; h24_mode = 1'b0;
        strobe(8'h00, 8'h00, 8'h12, 8'h00, 8'h00, 8'h92, 1'b0, "R5 12AM vs 12PM alarm");
        strobe(8'h00, 8'h00, 8'h92, 8'h00, 8'h00, 8'h92, 1'b1, "R5 12PM match");
        strobe(8'h00, 8'h00, 8'h12, 8'h00, 8'h00, 8'h12, 1'b1, "R5 12AM match");
        strobe(8'h00, 8'h00, 8'h81, 8'h00, 8'h00, 8'h01, 1'b0, "R5 1PM vs 1AM");
        // 12-hour binary
        bin_mode = 1'b1;
        strobe(8'h05, 8'h06, 8'h8B, 8'h05, 8'h06, 8'h8B, 1'b1, "R5 binary 11PM match");

        // Hold
        bin_mode = 1'b0; h24_mode = 1'b1;
        set_hold = 1'b1;
        strobe(8'h56, 8'h34, 8'h12, 8'h56, 8'h34, 8'h12, 1'b0, "R7 hold blocks match");
        set_hold = 1'b0;

        // R8: alarm written before strobe is used; change after strobe ignored
        @(negedge clk);
        set_vals(8'h10, 8'h20, 8'h08, 8'h11, 8'h20, 8'h08);
        gap(2);
        alm_sec = 8'h10;
        upd_tick = 1'b1;
        it.exp = 1'b1; it.tag = "R8 alarm written before strobe";
        sb.push_back(it);
        @(negedge clk);
        upd_tick = 1'b0;
        alm_sec = 8'h44;
        now_sec = 8'h45;
        gap(3);

        // R9: back-to-back strobes
        @(negedge clk);
        set_vals(8'h22, 8'h22, 8'h22, 8'h22, 8'h22, 8'h22);
        upd_tick = 1'b1;
        it.exp = 1'b1; it.tag = "R9 first strobe";
        sb.push_back(it);
        @(negedge clk);
        it.exp = 1'b0; it.tag = "R9 second strobe dropped";
        sb.push_back(it);
        @(negedge clk);
        upd_tick = 1'b0;
        gap(3);

        // R6: match right after a dropped-window still single pulse
        strobe(8'h22, 8'h22, 8'h22, 8'h22, 8'h22, 8'h22, 1'b1, "R6 pulse after recovery");

        gap(4);
        tests++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R6 pending results: actual %0d expected 0", sb.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule